// File: doc/BRIEF.md
# Sixteen-bit timer with pulse-width and single-pulse modes

The block is a 16-bit up-counter paced by a selectable time base, with two compare registers, two capture registers and two compare output pins. Software sets it up through a small word-wide register port. In the plain compare mode the counter runs freely. A match with either compare register loads a programmed level into that channel's output latch. The capture inputs latch the counter on a chosen transition.

In pulse-width mode the counter restarts after it matches compare register 2, so the cycle is set by compare register 2. Compare register 1 sets how long the active level lasts within each cycle. In single-pulse mode the counter sits at zero until a chosen edge on capture input 1 arrives. It then drives one active pulse whose length is set by compare register 1, and returns to idle. The time base is the system clock divided by 2, 4 or 8, or the synchronised transitions of an external clock input. Pin-enable bits only gate what reaches the pins.

Top module: `pulse_timer16`

## Requirements
- R1: After reset every register reads 0, the counter is 0, and both pins and both pin-enable outputs are low.
- R2: Register addresses: 0 control, 1 level/edge, 2 compare 1, 3 compare 2, 4 capture 1 (read only), 5 capture 2 (read only), 6 counter (read only). Control bits are 7 pin-1 enable, 6 pin-2 enable, 5 single-pulse, 4 pulse-width, 3:2 time base, 1 capture-2 edge, 0 external-clock edge. Level/edge bits are 2 capture-1 edge, 1 level B, 0 level A. Edge bits use 1 for rising and 0 for falling. Any write to the control register restarts the counter and the divider at 0.
- R3: Time base 00 advances the counter every 4 clocks, 01 every 2 clocks and 10 every 8 clocks. The counter never moves without a tick.
- R4: Time base 11 advances the counter once per synchronised external-clock transition of the selected polarity. If the external pin is configured absent, the counter stays frozen.
- R5: In plain compare mode the counter adds one per tick. A tick with the counter equal to compare 1 loads level A into the pin-1 latch. A tick with the counter equal to compare 2 loads level B into the pin-2 latch.
- R6: Capture 2 latches the counter on the capture-2 input edge chosen by control bit 1. Capture 1 latches it on the capture-1 edge chosen by level/edge bit 2. The opposite edge leaves the register unchanged.
- R7: In pulse-width mode the counter runs 0..compare 2 and reloads to 0. Pin 1 shows level B while the counter is below compare 1 and level A otherwise. With 1 <= compare 1 <= compare 2 the period is (compare 2 + 1)·N clocks and the level-B time is compare 1·N clocks, where N is the divider.
- R8: In single-pulse mode a selected edge on capture input 1 drives pin 1 to level B for exactly (compare 1 + 1)·N clocks, then back to level A. Outside a pulse the counter holds at 0.
- R9: Trigger edges that arrive during a pulse do not lengthen or restart it.
- R10: With both mode bits set, pulse-width mode applies and no single pulse is ever armed.
- R11: A pin whose enable bit is 0 reads 0, and its enable output is 0. Its compare latch keeps updating, so setting the enable shows the latched level at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| ext_clk | input | 1 | External time-base input |
| cap1_in | input | 1 | Capture input 1, also the single-pulse trigger |
| cap2_in | input | 1 | Capture input 2 |
| oc1_pin | output | 1 | Compare output pin 1 |
| oc1_oe | output | 1 | Pin 1 driven by the timer |
| oc2_pin | output | 1 | Compare output pin 2 |
| oc2_oe | output | 1 | Pin 2 driven by the timer |

## Verification
Pulse-width mode is driven with random compare pairs on random dividers, plus the case where compare 1 equals compare 2. Measuring both the level-B time and the full period separates a wrong width from a wrong reload point or a wrong divider. Single-pulse mode is run with random lengths, with length 0, and with extra trigger edges inside the pulse, which tells an off-by-one end apart from a retrigger. The external and capture paths are stepped by hand-made edges of both polarities, so a swapped edge select leaves a counter or capture value visibly wrong.

// File: rtl/tmr16_pkg.sv
`timescale 1ns/1ps
// Shared types and register map of the 16-bit timer.
package tmr16_pkg;
    typedef enum logic [1:0] {
        MODE_FREE    = 2'd0,
        MODE_PWM     = 2'd1,
        MODE_ONESHOT = 2'd2
    } tmr_mode_e;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_AUX  = 3'd1;
    localparam logic [ADDR_W-1:0] ADDR_CMP1 = 3'd2;
    localparam logic [ADDR_W-1:0] ADDR_CMP2 = 3'd3;
    localparam logic [ADDR_W-1:0] ADDR_CAP1 = 3'd4;
    localparam logic [ADDR_W-1:0] ADDR_CAP2 = 3'd5;
    localparam logic [ADDR_W-1:0] ADDR_CNT  = 3'd6;

    // control register bit positions
    localparam int C_PIN1_EN = 7;
    localparam int C_PIN2_EN = 6;
    localparam int C_ONESHOT = 5;
    localparam int C_PWM     = 4;
    localparam int C_CSEL_HI = 3;
    localparam int C_CSEL_LO = 2;
    localparam int C_CAP2_RE = 1;
    localparam int C_EXT_RE  = 0;

    // level/edge register bit positions
    localparam int A_CAP1_RE = 2;
    localparam int A_LVL_B   = 1;
    localparam int A_LVL_A   = 0;
endpackage

// File: rtl/tmr16_edge_det.sv
`timescale 1ns/1ps
// Synchronises an asynchronous input and flags one transition of the
// selected polarity for one clock. Assumes SYNC_STAGES >= 2 and that the
// input is low while reset is applied.
module tmr16_edge_det #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic rise_sel,
    output logic edge_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   cur;

    assign cur = sync_q[SYNC_STAGES-1];

    // shift the input through the synchroniser and keep the last level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], din};
            prev_q <= cur;
        end
    end

    // pick the transition polarity
    always_comb begin
        edge_o = rise_sel ? (cur & ~prev_q) : (~cur & prev_q);
    end
endmodule

// File: rtl/tmr16_clk_sel.sv
`timescale 1ns/1ps
// Time base: a free-running prescaler gives one-clock ticks every 2, 4 or 8
// clocks, or the external edge flag is used. A restart clears the prescaler
// so that the next internal tick comes a full divider period later.
// Assumes PRE_W >= 3.
module tmr16_clk_sel #(
    parameter int PRE_W       = 3,
    parameter bit HAS_EXT_CLK = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] clk_sel,
    input  logic       ext_edge,
    input  logic       restart,
    output logic       tick
);
    localparam logic [PRE_W-1:0] MASK_D2 = PRE_W'(1);
    localparam logic [PRE_W-1:0] MASK_D4 = PRE_W'(3);
    localparam logic [PRE_W-1:0] MASK_D8 = PRE_W'(7);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;
    logic             ext_tick;

    // prescaler count, cleared on restart
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    // an absent external pin yields no ticks at all
    assign ext_tick = ext_edge & HAS_EXT_CLK;

    // select the divider mask or the external tick
    always_comb begin
        mask = MASK_D4;
        tick = 1'b0;
        case (clk_sel)
            2'b00: mask = MASK_D4;
            2'b01: mask = MASK_D2;
            2'b10: mask = MASK_D8;
            default: mask = '0;
        endcase
        if (clk_sel == 2'b11) begin
            tick = ext_tick;
        end else begin
            tick = ((pre_q & mask) == mask);
        end
    end
endmodule

// File: rtl/tmr16_core.sv
`timescale 1ns/1ps
// Counter and mode engine. Plain mode counts freely and loads the compare
// latches on matches. Pulse-width mode reloads after compare 2 and derives
// pin 1 from compare 1. Single-pulse mode waits at zero for a trigger and
// runs until compare 1. Assumes mode only changes together with restart.
module tmr16_core
    import tmr16_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             restart,
    input  tmr_mode_e        mode,
    input  logic             trig,
    input  logic [CNT_W-1:0] cmp1,
    input  logic [CNT_W-1:0] cmp2,
    input  logic             lvl_a,
    input  logic             lvl_b,
    output logic [CNT_W-1:0] cnt,
    output logic             run,
    output logic             pin1_lvl,
    output logic             pin2_lvl,
    output logic             pre_clr
);
    logic [CNT_W-1:0] cnt_q;
    logic             run_q;
    logic             oc1_q;
    logic             oc2_q;
    logic             hit1;
    logic             hit2;

    assign hit1 = (cnt_q == cmp1);
    assign hit2 = (cnt_q == cmp2);

    // counter, pulse state and compare latches
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
            oc1_q <= 1'b0;
            oc2_q <= 1'b0;
        end else if (restart) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else begin
            if (tick && hit2) begin
                oc2_q <= lvl_b;
            end
            case (mode)
                MODE_PWM: begin
                    if (tick) begin
                        cnt_q <= hit2 ? '0 : cnt_q + 1'b1;
                    end
                end
                MODE_ONESHOT: begin
                    if (!run_q) begin
                        if (trig) begin
                            run_q <= 1'b1;
                        end
                    end else if (tick) begin
                        if (hit1) begin
                            run_q <= 1'b0;
                            cnt_q <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                default: begin
                    if (tick) begin
                        cnt_q <= cnt_q + 1'b1;
                        if (hit1) begin
                            oc1_q <= lvl_a;
                        end
                    end
                end
            endcase
        end
    end

    // pin-1 level per mode
    always_comb begin
        case (mode)
            MODE_PWM:     pin1_lvl = (cnt_q < cmp1) ? lvl_b : lvl_a;
            MODE_ONESHOT: pin1_lvl = run_q ? lvl_b : lvl_a;
            default:      pin1_lvl = oc1_q;
        endcase
    end

    // an accepted trigger realigns the prescaler
    assign pre_clr  = (mode == MODE_ONESHOT) && !run_q && trig;
    assign cnt      = cnt_q;
    assign run      = run_q;
    assign pin2_lvl = oc2_q;
endmodule

// File: rtl/pulse_timer16.sv
`timescale 1ns/1ps
// Top of the 16-bit timer: register file, read mux, input edge detectors,
// time base and counter engine. Pin enables gate only the pins.
// Assumes CNT_W >= 8 so that the control byte fits the data word.
module pulse_timer16
    import tmr16_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2,
    parameter bit HAS_EXT_CLK = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [2:0]       rd_addr,
    output logic [CNT_W-1:0] rd_data,
    input  logic             ext_clk,
    input  logic             cap1_in,
    input  logic             cap2_in,
    output logic             oc1_pin,
    output logic             oc1_oe,
    output logic             oc2_pin,
    output logic             oc2_oe
);
    localparam int N_EDGE = 3;
    localparam int E_EXT  = 0;
    localparam int E_CAP1 = 1;
    localparam int E_CAP2 = 2;

    logic [7:0]       ctrl_q;
    logic [2:0]       aux_q;
    logic [CNT_W-1:0] cmp1_q;
    logic [CNT_W-1:0] cmp2_q;
    logic [CNT_W-1:0] cap1_q;
    logic [CNT_W-1:0] cap2_q;
    logic [CNT_W-1:0] cnt_q;
    logic             ctrl_wr;
    logic             tick;
    logic             run;
    logic             pin1_lvl;
    logic             pin2_lvl;
    logic             pre_clr;
    tmr_mode_e        mode;

    logic [N_EDGE-1:0] edge_in;
    logic [N_EDGE-1:0] edge_sel;
    logic [N_EDGE-1:0] edge_hit;

    assign ctrl_wr = wr_en && (wr_addr == ADDR_CTRL);

    assign edge_in[E_EXT]   = ext_clk;
    assign edge_in[E_CAP1]  = cap1_in;
    assign edge_in[E_CAP2]  = cap2_in;
    assign edge_sel[E_EXT]  = ctrl_q[C_EXT_RE];
    assign edge_sel[E_CAP1] = aux_q[A_CAP1_RE];
    assign edge_sel[E_CAP2] = ctrl_q[C_CAP2_RE];

    for (genvar gi = 0; gi < N_EDGE; gi++) begin : g_edge
        tmr16_edge_det #(
            .SYNC_STAGES(SYNC_STAGES)
        ) u_edge (
            .clk     (clk),
            .rst_n   (rst_n),
            .din     (edge_in[gi]),
            .rise_sel(edge_sel[gi]),
            .edge_o  (edge_hit[gi])
        );
    end

    // mode decode, pulse-width wins over single-pulse
    always_comb begin
        if (ctrl_q[C_PWM]) begin
            mode = MODE_PWM;
        end else if (ctrl_q[C_ONESHOT]) begin
            mode = MODE_ONESHOT;
        end else begin
            mode = MODE_FREE;
        end
    end

    // software registers and capture latches
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            aux_q  <= '0;
            cmp1_q <= '0;
            cmp2_q <= '0;
            cap1_q <= '0;
            cap2_q <= '0;
        end else begin
            if (wr_en) begin
                case (wr_addr)
                    ADDR_CTRL: ctrl_q <= wr_data[7:0];
                    ADDR_AUX:  aux_q  <= wr_data[2:0];
                    ADDR_CMP1: cmp1_q <= wr_data;
                    ADDR_CMP2: cmp2_q <= wr_data;
                    default: ;
                endcase
            end
            if (edge_hit[E_CAP1]) begin
                cap1_q <= cnt_q;
            end
            if (edge_hit[E_CAP2]) begin
                cap2_q <= cnt_q;
            end
        end
    end

    tmr16_clk_sel #(
        .PRE_W      (3),
        .HAS_EXT_CLK(HAS_EXT_CLK)
    ) u_clk_sel (
        .clk     (clk),
        .rst_n   (rst_n),
        .clk_sel (ctrl_q[C_CSEL_HI:C_CSEL_LO]),
        .ext_edge(edge_hit[E_EXT]),
        .restart (ctrl_wr | pre_clr),
        .tick    (tick)
    );

    tmr16_core #(
        .CNT_W(CNT_W)
    ) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .restart (ctrl_wr),
        .mode    (mode),
        .trig    (edge_hit[E_CAP1]),
        .cmp1    (cmp1_q),
        .cmp2    (cmp2_q),
        .lvl_a   (aux_q[A_LVL_A]),
        .lvl_b   (aux_q[A_LVL_B]),
        .cnt     (cnt_q),
        .run     (run),
        .pin1_lvl(pin1_lvl),
        .pin2_lvl(pin2_lvl),
        .pre_clr (pre_clr)
    );

    // register read mux
    always_comb begin
        case (rd_addr)
            ADDR_CTRL: rd_data = CNT_W'(ctrl_q);
            ADDR_AUX:  rd_data = CNT_W'(aux_q);
            ADDR_CMP1: rd_data = cmp1_q;
            ADDR_CMP2: rd_data = cmp2_q;
            ADDR_CAP1: rd_data = cap1_q;
            ADDR_CAP2: rd_data = cap2_q;
            ADDR_CNT:  rd_data = cnt_q;
            default:   rd_data = '0;
        endcase
    end

    assign oc1_oe  = ctrl_q[C_PIN1_EN];
    assign oc2_oe  = ctrl_q[C_PIN2_EN];
    assign oc1_pin = oc1_oe & pin1_lvl;
    assign oc2_pin = oc2_oe & pin2_lvl;
endmodule

// File: rtl/tmr16_chk.sv
`timescale 1ns/1ps
// Checker for pulse_timer16: relates the counter, the time-base tick and
// the pulse state across cycles. Attached to every instance by bind.
module tmr16_chk
    import tmr16_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             tick,
    input logic             run,
    input tmr_mode_e        mode,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] cmp2
);
    // R3: no tick and no write, so the counter keeps its value
    a_r3_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_en) |=> $stable(cnt));

    // R5: plain mode steps by one per tick
    a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_FREE && tick && !wr_en) |=> (cnt == $past(cnt) + 1'b1));

    // R7: pulse-width counter stays within 0..compare 2
    a_r7_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_PWM && cnt <= cmp2 && !wr_en) |=> (cnt <= cmp2));

    // R8: idle single-pulse counter sits at zero
    a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_ONESHOT && !run && !wr_en) |=> (cnt == '0));

    // R9: a running pulse only ends on a tick
    a_r9_no_early_end: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick && !wr_en) |=> run);

    // R10: pulse-width mode never has a pulse armed
    a_r10_prio: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_PWM) |-> !run);
endmodule

bind pulse_timer16 tmr16_chk #(
    .CNT_W(CNT_W)
) u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .wr_en(wr_en),
    .tick (tick),
    .run  (run),
    .mode (mode),
    .cnt  (cnt_q),
    .cmp2 (cmp2_q)
);

// File: tb/pulse_timer16_tb.sv
`timescale 1ns/1ps
// Bench for pulse_timer16: directed corner cases plus seeded random
// compare values; expected results come from bench functions.
module pulse_timer16_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic [15:0] rd_data_nx;
    logic        ext_clk = 1'b0;
    logic        cap1_in = 1'b0;
    logic        cap2_in = 1'b0;
    logic        oc1_pin, oc1_oe, oc2_pin, oc2_oe;
    logic        nx_p1, nx_e1, nx_p2, nx_e2;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    pulse_timer16 u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .ext_clk(ext_clk), .cap1_in(cap1_in), .cap2_in(cap2_in),
        .oc1_pin(oc1_pin), .oc1_oe(oc1_oe), .oc2_pin(oc2_pin), .oc2_oe(oc2_oe)
    );

    // same stimulus, external clock pin configured absent
    pulse_timer16 #(.HAS_EXT_CLK(1'b0)) u_dut_nx (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data_nx),
        .ext_clk(ext_clk), .cap1_in(cap1_in), .cap2_in(cap2_in),
        .oc1_pin(nx_p1), .oc1_oe(nx_e1), .oc2_pin(nx_p2), .oc2_oe(nx_e2)
    );

    function automatic int div_of(input int cc);
        case (cc)
            0: return 4;
            1: return 2;
            2: return 8;
            default: return 0;
        endcase
    endfunction

    function automatic int pwm_high(input int c1, input int cc);
        return c1 * div_of(cc);
    endfunction

    function automatic int pwm_period(input int c2, input int cc);
        return (c2 + 1) * div_of(cc);
    endfunction

    function automatic int pulse_len(input int c1, input int cc);
        return (c1 + 1) * div_of(cc);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int d);
        rd_addr = a;
        #1;
        d = int'(rd_data);
    endtask

    task automatic rd_nx(input logic [2:0] a, output int d);
        rd_addr = a;
        #1;
        d = int'(rd_data_nx);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // waits for a rising pin 1, then counts high and total cycles
    task automatic measure_pwm(output int hi, output int per);
        logic prev;
        int   guard;
        int   lo;
        hi = 0;
        lo = 0;
        guard = 0;
        @(negedge clk);
        prev = oc1_pin;
        @(negedge clk);
        while (!(!prev && oc1_pin) && guard < 3000) begin
            prev = oc1_pin;
            guard++;
            @(negedge clk);
        end
        while (oc1_pin && hi < 3000) begin
            hi++;
            @(negedge clk);
        end
        while (!oc1_pin && lo < 3000) begin
            lo++;
            @(negedge clk);
        end
        per = hi + lo;
    endtask

    // fires one pulse, optionally with extra trigger edges inside it
    task automatic fire_pulse(input bit retrig, output int hi);
        int guard;
        hi = 0;
        guard = 0;
        @(negedge clk);
        cap1_in = 1'b1;
        while (!oc1_pin && guard < 100) begin
            guard++;
            @(negedge clk);
        end
        while (oc1_pin && hi < 3000) begin
            hi++;
            if (retrig && hi == 2) cap1_in = 1'b0;
            if (retrig && hi == 5) cap1_in = 1'b1;
            @(negedge clk);
        end
        cap1_in = 1'b0;
        idle(6);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        int v, v2, hi, per, c0, c1, cc, cmp1, cmp2;
        v = $urandom(32'h5eed_0017);

        idle(4);
        rst_n = 1'b1;
        idle(2);

        // R1: reset state
        for (int a = 0; a < 7; a++) begin
            rd(a[2:0], v);
            chk(v == 0, "R1 register reset", v, 0);
        end
        chk({oc1_pin, oc1_oe, oc2_pin, oc2_oe} == 4'b0, "R1 pins low",
            int'({oc1_pin, oc1_oe, oc2_pin, oc2_oe}), 0);

        // R2: read-back of writable registers
        wr(3'd2, 16'hA5C3);
        rd(3'd2, v);
        chk(v == 16'hA5C3, "R2 compare 1 readback", v, 16'hA5C3);
        wr(3'd1, 16'h0005);
        rd(3'd1, v);
        chk(v == 5, "R2 level/edge readback", v, 5);
        wr(3'd0, 16'h0008);
        rd(3'd0, v);
        chk(v == 8, "R2 control readback", v, 8);

        // R3: each divider rate over a 64-clock window
        for (int k = 0; k < 3; k++) begin
            wr(3'd0, 16'(k << 2));
            rd(3'd6, c0);
            idle(64);
            rd(3'd6, c1);
            chk(c1 - c0 == 64 / div_of(k), "R3 divider rate", c1 - c0, 64 / div_of(k));
        end

        // R4: external clock, rising edges
        wr(3'd0, 16'h000D);
        for (int p = 0; p < 5; p++) begin
            ext_clk = 1'b1;
            idle(4);
            ext_clk = 1'b0;
            idle(4);
        end
        rd(3'd6, v);
        chk(v == 5, "R4 external rising count", v, 5);
        rd_nx(3'd6, v);
        chk(v == 0, "R4 absent external pin frozen", v, 0);

        // R6: capture 2 on falling edge only
        cap2_in = 1'b1;
        idle(5);
        rd(3'd5, v);
        chk(v == 0, "R6 capture 2 ignores rising", v, 0);
        cap2_in = 1'b0;
        idle(5);
        rd(3'd5, v);
        chk(v == 5, "R6 capture 2 on falling", v, 5);
        // R6: capture 1 on rising edge
        wr(3'd1, 16'h0004);
        cap1_in = 1'b1;
        idle(5);
        rd(3'd4, v);
        chk(v == 5, "R6 capture 1 on rising", v, 5);
        cap1_in = 1'b0;
        idle(5);
        rd(3'd4, v);
        chk(v == 5, "R6 capture 1 ignores falling", v, 5);

        // R4: external clock, falling edges
        wr(3'd0, 16'h000C);
        ext_clk = 1'b1;
        idle(5);
        rd(3'd6, v);
        chk(v == 0, "R4 falling mode ignores rising", v, 0);
        ext_clk = 1'b0;
        idle(5);
        rd(3'd6, v);
        chk(v == 1, "R4 falling mode counts falling", v, 1);

        // R5/R11: compare latches with pins disabled, then enabled
        wr(3'd1, 16'h0003);
        wr(3'd2, 16'd10);
        wr(3'd3, 16'd20);
        wr(3'd0, 16'h0004);
        idle(60);
        chk(oc1_pin == 1'b0 && oc1_oe == 1'b0, "R11 disabled pin 1 low",
            int'({oc1_pin, oc1_oe}), 0);
        chk(oc2_pin == 1'b0 && oc2_oe == 1'b0, "R11 disabled pin 2 low",
            int'({oc2_pin, oc2_oe}), 0);
        wr(3'd0, 16'h00C4);
        chk(oc1_pin == 1'b1 && oc1_oe == 1'b1, "R5 R11 pin 1 latched level A",
            int'({oc1_pin, oc1_oe}), 3);
        chk(oc2_pin == 1'b1 && oc2_oe == 1'b1, "R5 R11 pin 2 latched level B",
            int'({oc2_pin, oc2_oe}), 3);

        // R7: pulse-width mode, directed compare1 == compare2 then random
        wr(3'd1, 16'h0002);
        for (int it = 0; it < 7; it++) begin
            if (it == 0) begin
                cc = 1; cmp2 = 6; cmp1 = 6;
            end else begin
                cc = int'($urandom % 3);
                cmp2 = 2 + int'($urandom % 20);
                cmp1 = 1 + int'($urandom % cmp2);
            end
            wr(3'd2, 16'(cmp1));
            wr(3'd3, 16'(cmp2));
            wr(3'd0, 16'(8'h90 | (cc << 2)));
            measure_pwm(hi, per);
            chk(hi == pwm_high(cmp1, cc), "R7 level-B width", hi, pwm_high(cmp1, cc));
            chk(per == pwm_period(cmp2, cc), "R7 period", per, pwm_period(cmp2, cc));
        end

        // R10: both mode bits set behaves as pulse-width, triggers ignored
        wr(3'd1, 16'h0006);
        wr(3'd2, 16'd3);
        wr(3'd3, 16'd7);
        wr(3'd0, 16'h00B4);
        cap1_in = 1'b1;
        measure_pwm(hi, per);
        cap1_in = 1'b0;
        chk(hi == pwm_high(3, 1), "R10 priority width", hi, pwm_high(3, 1));
        chk(per == pwm_period(7, 1), "R10 priority period", per, pwm_period(7, 1));

        // R8: single pulses, directed length 0 then random
        for (int it = 0; it < 6; it++) begin
            cc = (it == 0) ? 2 : int'($urandom % 3);
            cmp1 = (it == 0) ? 0 : int'($urandom % 12);
            wr(3'd2, 16'(cmp1));
            wr(3'd0, 16'(8'hA0 | (cc << 2)));
            fire_pulse(1'b0, hi);
            chk(hi == pulse_len(cmp1, cc), "R8 pulse length", hi, pulse_len(cmp1, cc));
            rd(3'd6, v);
            chk(v == 0 && oc1_pin == 1'b0, "R8 idle after pulse", v, 0);
        end

        // R9: extra edges during a pulse do not extend it
        wr(3'd2, 16'd9);
        wr(3'd0, 16'h00A4);
        fire_pulse(1'b1, hi);
        chk(hi == pulse_len(9, 1), "R9 retrigger ignored", hi, pulse_len(9, 1));
        idle(30);
        rd(3'd6, v2);
        chk(v2 == 0 && oc1_pin == 1'b0, "R9 no second pulse", v2, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule